// File: doc/BRIEF.md
# Maskable Cascadable Interrupt Controller

This block collects a set of interrupt request lines and merges them into one interrupt request for the processor. Each line has a bit in a sticky event register that records a request once it arrives and keeps it until software acknowledges it. A per-line mask decides which recorded events can drive the processor request. The event bit is latched whether the line is masked or not, so software can also poll for masked causes.

Software reaches the block through a small register bus. It can read and write the mask, read the event register, and acknowledge events by writing ones to it. It can also read the unmasked events, and read a summary word that names the lowest-numbered unmasked event. Lines listed in a level-mode parameter are sampled as levels instead of edges. A downstream controller's output is wired to such a line, so that several controllers can be chained. The event bit of a level line is set again on every cycle while the slave still requests, so an acknowledge on the master cannot lose the slave's request.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask register (address 0) reads all ones, the event register (address 1) reads zero, and `irq_o` is low.
- R2: On an edge-mode line, a low-to-high change of `req_i` sets the matching event bit, whether or not the line is masked. A line held high sets the bit only once, so a bit cleared while its line stays high remains clear.
- R3: On a level-mode line (bit set in `LEVEL_LINES`), the event bit is set on every cycle in which `req_i` is high, so an acknowledge during an active request has no lasting effect.
- R4: `irq_o` is high exactly when some event bit is set while its mask bit is 0.
- R5: A bus write to address 1 clears each event bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R6: If a set condition and a clear of the same event bit happen in the same cycle, the bit ends set.
- R7: The mask register at address 0 is read/write, and a 1 masks the line. Changing the mask never alters the event register.
- R8: A read of address 2 returns the event bits ANDed with the inverted mask. Writes to addresses 2 and 3 change no register.
- R9: A read of address 3 returns the index of the lowest-numbered unmasked set event in the low $clog2(N_LINES) bits, with bit N_LINES-1 set when such an event exists. When none exists it returns zero.
- R10: When a slave controller's `irq_o` drives a level-mode line of a master, the master's event bit for that line follows the slave's request. It can be cleared on the master only after the slave's request has been removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_LINES | Interrupt request lines, synchronous to `clk` |
| bus_addr | input | 2 | Register select: 0 mask, 1 events, 2 pending, 3 summary |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Merged interrupt request to the processor |

## Verification
The assertions check four things on every cycle. A set beats a simultaneous clear. Written-one bits that are not being set go to zero. An event bit only changes when a set or clear is applied to it. The mask only moves on a mask write. They also check that the merged request agrees with the priority finder, and that the reported index is the lowest pending one. Other behaviour can only be shown by the bench's scenarios: edge versus level detection on held lines, masking that leaves events intact, writes to read-only addresses, and the behaviour of a two-controller chain over several cycles.

// File: rtl/irqc_pkg.sv
// Package: shared register selector for the interrupt controller.
// Assumes a two-bit register address on the bus.
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_EVT  = 2'd1,
        SEL_PEND = 2'd2,
        SEL_TOP  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqc_trigger.sv
// Module: per-line set detection.
// Edge-mode lines produce a one-cycle set on a low-to-high change.
// Level-mode lines produce a set on every cycle the line is high.
// Assumes req_i is already synchronous to clk.
module irqc_trigger #(
    parameter int                   N_LINES     = 8,
    parameter logic [N_LINES-1:0]   LEVEL_LINES = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    output logic [N_LINES-1:0] set_o
);

    logic [N_LINES-1:0] prev_q;

    // Remember last cycle's request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req_i;
    end

    // Pick edge or level detection per line.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (LEVEL_LINES[i]) begin : g_level
            assign set_o[i] = req_i[i];
        end else begin : g_edge
            assign set_o[i] = req_i[i] & ~prev_q[i];
        end
    end

endmodule

// File: rtl/irqc_latch.sv
// Module: sticky event register and mask register.
// Event bits are set by set_i and cleared by ones in clr_i. A set
// beats a clear in the same cycle. The mask resets to all ones.
module irqc_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] set_i,
    input  logic [N_LINES-1:0] clr_i,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wdata,
    output logic [N_LINES-1:0] evt_o,
    output logic [N_LINES-1:0] mask_o
);

    logic [N_LINES-1:0] evt_q;
    logic [N_LINES-1:0] mask_q;

    // Update event bits: apply clears, then let sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_i) | set_i;
    end

    // Load the mask on a mask write; all lines masked from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign evt_o  = evt_q;
    assign mask_o = mask_q;

    // R6: every bit set last cycle is set now, whatever was cleared.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));

    // R5: bits cleared without a competing set go to zero.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((evt_q & $past(clr_i & ~set_i)) == '0));

    // R2: an event bit changes only when a set or clear touches it.
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((evt_q ^ $past(evt_q)) & ~$past(set_i | clr_i)) == '0));

    // R7: the mask moves only on a mask write.
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

endmodule

// File: rtl/irqc_prio.sv
// Module: fixed-priority finder, lowest index wins.
// Purely combinational; idx_o is zero when nothing is pending.
module irqc_prio #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] pend_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top down so the lowest set index is kept.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    logic [N_LINES-1:0] below;
    assign below = (N_LINES'(1) << idx_o) - N_LINES'(1);

    // R9: the reported line is pending and nothing below it is.
    always_comb begin
        if (valid_o) begin
            p_lowest_r9: assert (pend_i[idx_o] && ((pend_i & below) == '0));
        end
    end

endmodule

// File: rtl/irqc_top.sv
// Module: maskable, chainable interrupt controller top.
// Register bus: address 0 mask (RW), 1 events (read, write-one-clear),
// 2 pending (RO), 3 summary (RO). Reads are combinational.
// Assumes N_LINES >= $clog2(N_LINES) + 1 so the summary fits.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                   N_LINES     = 8,
    parameter logic [N_LINES-1:0]   LEVEL_LINES = {1'b1, {(N_LINES-1){1'b0}}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic [1:0]         bus_addr,
    input  logic               bus_we,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_o
);

    localparam int IDX_W = $clog2(N_LINES);

    reg_sel_e           sel;
    logic [N_LINES-1:0] set_vec;
    logic [N_LINES-1:0] clr_vec;
    logic [N_LINES-1:0] evt;
    logic [N_LINES-1:0] mask;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] summary;
    logic               mask_we;
    logic               top_valid;
    logic [IDX_W-1:0]   top_idx;

    assign sel = reg_sel_e'(bus_addr);

    // Decode the bus write into a mask load and an acknowledge vector.
    always_comb begin
        mask_we = bus_we && (sel == SEL_MASK);
        clr_vec = (bus_we && (sel == SEL_EVT)) ? bus_wdata : '0;
    end

    irqc_trigger #(
        .N_LINES     (N_LINES),
        .LEVEL_LINES (LEVEL_LINES)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .set_o (set_vec)
    );

    irqc_latch #(
        .N_LINES (N_LINES)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata),
        .evt_o      (evt),
        .mask_o     (mask)
    );

    assign pend  = evt & ~mask;
    assign irq_o = |pend;

    irqc_prio #(
        .N_LINES (N_LINES),
        .IDX_W   (IDX_W)
    ) u_prio (
        .pend_i  (pend),
        .valid_o (top_valid),
        .idx_o   (top_idx)
    );

    // Build the summary word: valid flag on top, index at the bottom.
    always_comb begin
        summary              = '0;
        summary[IDX_W-1:0]   = top_idx;
        summary[N_LINES-1]   = top_valid;
    end

    // Return the selected register.
    always_comb begin
        unique case (sel)
            SEL_MASK: bus_rdata = mask;
            SEL_EVT:  bus_rdata = evt;
            SEL_PEND: bus_rdata = pend;
            SEL_TOP:  bus_rdata = summary;
            default:  bus_rdata = '0;
        endcase
    end

    // R4: the merged request agrees with the priority finder.
    p_irq_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == top_valid);

endmodule

// File: tb/sim_irqc_top.sv
// Directed bench: a master controller with a slave chained onto its
// level-mode line 7. Inputs change on falling edges and outputs are
// sampled on falling edges.
module sim_irqc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_req = '0;
    logic [1:0] m_addr = '0;
    logic       m_we = 1'b0;
    logic [7:0] m_wdata = '0;
    logic [7:0] m_rdata;
    logic       m_irq;
    logic [7:0] s_req = '0;
    logic [1:0] s_addr = '0;
    logic       s_we = 1'b0;
    logic [7:0] s_wdata = '0;
    logic [7:0] s_rdata;
    logic       s_irq;
    logic [7:0] m_lines;

    int checks = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign m_lines = {s_irq, m_req[6:0]};

    irqc_top #(.N_LINES(8), .LEVEL_LINES(8'h80)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(m_lines), .bus_addr(m_addr),
        .bus_we(m_we), .bus_wdata(m_wdata), .bus_rdata(m_rdata), .irq_o(m_irq)
    );

    irqc_top #(.N_LINES(8), .LEVEL_LINES(8'h00)) u1 (
        .clk(clk), .rst_n(rst_n), .req_i(s_req), .bus_addr(s_addr),
        .bus_we(s_we), .bus_wdata(s_wdata), .bus_rdata(s_rdata), .irq_o(s_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        m_addr = a; m_wdata = d; m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0;
    endtask

    task automatic swr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        s_addr = a; s_wdata = d; s_we = 1'b1;
        @(negedge clk);
        s_we = 1'b0;
    endtask

    task automatic mrd(input logic [1:0] a, output logic [7:0] d);
        m_addr = a;
        #1;
        d = m_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        m_req[line] = 1'b1;
        @(negedge clk);
        m_req[line] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        mrd(2'd0, v); chk("R1", "mask after reset", v, 8'hFF);
        mrd(2'd1, v); chk("R1", "events after reset", v, 8'h00);
        chk("R1", "irq after reset", {7'b0, m_irq}, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        @(negedge clk);
        m_req[2] = 1'b1;
        @(negedge clk);
        mrd(2'd1, v); chk("R2", "masked edge latched", v, 8'h04);
        chk("R2", "masked edge no irq", {7'b0, m_irq}, 8'h00);
        mwr(2'd1, 8'h04);
        repeat (3) @(negedge clk);
        mrd(2'd1, v); chk("R2", "held line not re-set", v, 8'h00);
        m_req[2] = 1'b0;
    endtask

    task automatic t_mask();
        logic [7:0] v;
        mwr(2'd0, 8'hFB);
        mrd(2'd0, v); chk("R7", "mask readback", v, 8'hFB);
        pulse(2);
        chk("R4", "unmasked event raises irq", {7'b0, m_irq}, 8'h01);
        mrd(2'd2, v); chk("R8", "pending value", v, 8'h04);
        mwr(2'd0, 8'hFF);
        chk("R4", "masking drops irq", {7'b0, m_irq}, 8'h00);
        mrd(2'd1, v); chk("R7", "mask keeps event", v, 8'h04);
        mrd(2'd2, v); chk("R8", "pending when masked", v, 8'h00);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        pulse(1);
        pulse(5);
        mrd(2'd1, v); chk("R5", "events before ack", v, 8'h26);
        mwr(2'd1, 8'h02);
        mrd(2'd1, v); chk("R5", "one-bit ack", v, 8'h24);
        mwr(2'd1, 8'h00);
        mrd(2'd1, v); chk("R5", "zero write keeps events", v, 8'h24);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        mwr(2'd0, 8'h00);
        mrd(2'd3, v); chk("R9", "lowest pending index 2", v, 8'h82);
        mwr(2'd1, 8'h04);
        mrd(2'd3, v); chk("R9", "next pending index 5", v, 8'h85);
        mwr(2'd1, 8'hFF);
        mrd(2'd3, v); chk("R9", "none pending", v, 8'h00);
        chk("R4", "irq low when empty", {7'b0, m_irq}, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        pulse(4);
        @(negedge clk);
        m_req[3] = 1'b1;
        m_addr = 2'd1; m_wdata = 8'h18; m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0; m_req[3] = 1'b0;
        mrd(2'd1, v); chk("R6", "set beats clear", v, 8'h08);
        mwr(2'd1, 8'hFF);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        pulse(6);
        mwr(2'd0, 8'hF0);
        mwr(2'd2, 8'hFF);
        mwr(2'd3, 8'hFF);
        mrd(2'd0, v); chk("R8", "mask after RO writes", v, 8'hF0);
        mrd(2'd1, v); chk("R8", "events after RO writes", v, 8'h40);
        mwr(2'd1, 8'hFF);
    endtask

    task automatic t_cascade();
        logic [7:0] v;
        mwr(2'd0, 8'h7F);
        swr(2'd0, 8'hFE);
        @(negedge clk);
        s_req[0] = 1'b1;
        @(negedge clk);
        s_req[0] = 1'b0;
        @(negedge clk);
        mrd(2'd1, v); chk("R10", "slave request reaches master", v, 8'h80);
        chk("R10", "master irq from slave", {7'b0, m_irq}, 8'h01);
        mwr(2'd1, 8'h80);
        mrd(2'd1, v); chk("R3", "level line re-sets after ack", v, 8'h80);
        swr(2'd1, 8'h01);
        chk("R10", "slave irq cleared", {7'b0, s_irq}, 8'h00);
        mwr(2'd1, 8'h80);
        mrd(2'd1, v); chk("R10", "master clears after slave", v, 8'h00);
        chk("R10", "master irq low", {7'b0, m_irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_mask();
        t_ack();
        t_prio();
        t_race();
        t_readonly();
        t_cascade();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule